// File: doc/BRIEF.md
# Decode-Stage Branch Resolver

This block settles conditional branches while they sit in the decode stage of a five-stage in-order pipeline. It receives the decoded branch kind, the two source operand values read in decode, the sign-extended immediate and the sequential fetch address (the branch's own address plus four). It evaluates the branch test and computes the jump target with an adder of its own. When the branch is taken, it tells the fetch logic to load the target. The test is limited to zero, non-zero, equality and sign checks, so the result is known one stage earlier than an execute-stage compare would give it.

The parameter `DELAY_SLOT` selects how the instruction fetched behind a taken branch is handled. With a value of 0 the pipeline predicts not-taken. The instruction that was fetched sequentially is then squashed into a no-op when the branch turns out taken. With a value of 1 that instruction is an architectural delay slot and always executes. In both modes the fetch address changes to the target on the clock edge that ends the branch's decode cycle. The block also detects operand dependences on instructions that are still in flight. It holds a branch in decode until its operands can be forwarded.

Top module: `br_resolve_unit`

## Requirements
- R1: After synchronous reset, a valid branch whose condition holds redirects in its first decode cycle, so `pc_sel` is 1 and no earlier redirect suppresses it.
- R2: `br_kind` encodes 0 as no branch, 1 as taken if A equals B, 2 as taken if A differs from B, 3 as taken if A is zero, 4 as taken if A is non-zero (every bit of A counts), 5 as taken if A is negative (bit 31), and 6 as taken if A is not negative. Codes 0 and 7 never redirect.
- R3: `br_target` equals `pc_plus4` plus `offset_imm` shifted left by two, modulo 2^32, and this holds for negative offsets too.
- R4: A valid branch stalls (`br_stall` = 1) when a source register it uses equals `ex_rd` and `ex_wen` is 1. Kinds 1 and 2 use `rs_idx` and `rt_idx`. All other kinds use only `rs_idx`.
- R5: A valid branch also stalls when a source register it uses equals `mem_rd` and `mem_load` is 1. A load one stage ahead therefore costs two stall cycles, and an ALU result one stage ahead costs one.
- R6: While `br_stall` is 1, both `pc_sel` and `flush_if` are 0.
- R7: With `DELAY_SLOT` = 0, `flush_if` equals `pc_sel`. A branch that is not taken flushes nothing.
- R8: With `DELAY_SLOT` = 1, `flush_if` is always 0, while `pc_sel` behaves as in R7.
- R9: In the cycle after a redirect, the instruction in decode (the squashed or slot instruction) never redirects or stalls, whatever its inputs.
- R10: Register index 0 never causes a stall, and `rt_idx` never causes a stall for kinds 3 to 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_valid | input | 1 | The decode stage holds a valid instruction |
| br_kind | input | 3 | Branch kind code (see R2) |
| opnd_a | input | 32 | First source operand value |
| opnd_b | input | 32 | Second source operand value |
| offset_imm | input | 32 | Sign-extended word offset |
| pc_plus4 | input | 32 | Sequential fetch address after the branch |
| rs_idx | input | 5 | First source register index |
| rt_idx | input | 5 | Second source register index |
| ex_wen | input | 1 | The instruction in execute writes a register |
| ex_rd | input | 5 | Destination of the instruction in execute |
| mem_load | input | 1 | The instruction in memory stage is a load |
| mem_rd | input | 5 | Destination of the instruction in memory stage |
| pc_sel | output | 1 | 1 selects `br_target` as the next fetch address |
| br_target | output | 32 | Computed taken target |
| flush_if | output | 1 | Turn the instruction now in fetch into a no-op |
| br_stall | output | 1 | Hold the branch in decode this cycle |

## Verification
Two functions can fall in the same cycle. The first pair is a taken condition and an operand hazard: the bench gives a branch whose operand values already satisfy the test but whose source register matches a pending writer. It expects a stall with no redirect and no flush, then a redirect in the first cycle after the hazard clears. The second pair is the shadow suppression and a fresh branch: a taken branch is placed right behind a redirect. Its output must stay idle, and in delay-slot mode the flush must stay low throughout.

// File: rtl/br_resolve_pkg.sv
package br_resolve_pkg;

    typedef enum logic [2:0] {
        BK_NONE = 3'd0,
        BK_EQ   = 3'd1,
        BK_NE   = 3'd2,
        BK_EZ   = 3'd3,
        BK_NZ   = 3'd4,
        BK_LTZ  = 3'd5,
        BK_GEZ  = 3'd6,
        BK_RSV  = 3'd7
    } br_kind_e;

    typedef struct packed {
        logic redirect;
        logic flush;
        logic stall;
    } br_ctl_t;

    function automatic logic kind_uses_rt(input br_kind_e k);
        return (k == BK_EQ) || (k == BK_NE);
    endfunction

    function automatic logic kind_is_branch(input br_kind_e k);
        return (k != BK_NONE) && (k != BK_RSV);
    endfunction

endpackage

// File: rtl/br_cond_eval.sv
module br_cond_eval
    import br_resolve_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  br_kind_e             kind,
    input  logic [XLEN-1:0]      a,
    input  logic [XLEN-1:0]      b,
    output logic                 taken
);
    logic a_zero;
    logic ab_same;
    logic a_neg;

    assign a_zero  = ~|a;
    assign ab_same = ~|(a ^ b);
    assign a_neg   = a[XLEN-1];

    always_comb begin
        unique case (kind)
            BK_EQ:   taken = ab_same;
            BK_NE:   taken = ~ab_same;
            BK_EZ:   taken = a_zero;
            BK_NZ:   taken = ~a_zero;
            BK_LTZ:  taken = a_neg;
            BK_GEZ:  taken = ~a_neg;
            default: taken = 1'b0;
        endcase
    end
endmodule

// File: rtl/br_target_add.sv
module br_target_add #(
    parameter int XLEN   = 32,
    parameter int ISHIFT = 2
) (
    input  logic [XLEN-1:0] seq_pc,
    input  logic [XLEN-1:0] offs,
    output logic [XLEN-1:0] target
);
    logic [XLEN-1:0] byte_offs;

    assign byte_offs = offs << ISHIFT;
    assign target    = seq_pc + byte_offs;
endmodule

// File: rtl/br_hazard_det.sv
module br_hazard_det #(
    parameter int REG_AW = 5
) (
    input  logic [REG_AW-1:0] src0,
    input  logic [REG_AW-1:0] src1,
    input  logic              src1_used,
    input  logic              ex_wen,
    input  logic [REG_AW-1:0] ex_rd,
    input  logic              mem_load,
    input  logic [REG_AW-1:0] mem_rd,
    output logic              hazard
);
    localparam int NSRC = 2;

    logic [REG_AW-1:0] src   [NSRC];
    logic [NSRC-1:0]   used;
    logic [NSRC-1:0]   hit;

    assign src[0]  = src0;
    assign src[1]  = src1;
    assign used[0] = 1'b1;
    assign used[1] = src1_used;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        logic nz;
        logic ex_hit;
        logic mem_hit;
        assign nz      = |src[i];
        assign ex_hit  = ex_wen   && (ex_rd  == src[i]);
        assign mem_hit = mem_load && (mem_rd == src[i]);
        assign hit[i]  = used[i] && nz && (ex_hit || mem_hit);
    end

    assign hazard = |hit;
endmodule

// File: rtl/br_resolve_unit.sv
module br_resolve_unit
    import br_resolve_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int REG_AW     = 5,
    parameter bit DELAY_SLOT = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              id_valid,
    input  logic [2:0]        br_kind,
    input  logic [XLEN-1:0]   opnd_a,
    input  logic [XLEN-1:0]   opnd_b,
    input  logic [XLEN-1:0]   offset_imm,
    input  logic [XLEN-1:0]   pc_plus4,
    input  logic [REG_AW-1:0] rs_idx,
    input  logic [REG_AW-1:0] rt_idx,
    input  logic              ex_wen,
    input  logic [REG_AW-1:0] ex_rd,
    input  logic              mem_load,
    input  logic [REG_AW-1:0] mem_rd,
    output logic              pc_sel,
    output logic [XLEN-1:0]   br_target,
    output logic              flush_if,
    output logic              br_stall
);
    br_kind_e kind;
    logic     cond_true;
    logic     hazard;
    logic     shadow_q;
    logic     active;
    br_ctl_t  ctl;

    assign kind = br_kind_e'(br_kind);

    br_cond_eval #(.XLEN(XLEN)) u_cond (
        .kind  (kind),
        .a     (opnd_a),
        .b     (opnd_b),
        .taken (cond_true)
    );

    br_target_add #(.XLEN(XLEN), .ISHIFT(2)) u_tgt (
        .seq_pc (pc_plus4),
        .offs   (offset_imm),
        .target (br_target)
    );

    br_hazard_det #(.REG_AW(REG_AW)) u_haz (
        .src0      (rs_idx),
        .src1      (rt_idx),
        .src1_used (kind_uses_rt(kind)),
        .ex_wen    (ex_wen),
        .ex_rd     (ex_rd),
        .mem_load  (mem_load),
        .mem_rd    (mem_rd),
        .hazard    (hazard)
    );

    assign active = id_valid && kind_is_branch(kind) && !shadow_q;

    always_comb begin
        ctl.stall    = active && hazard;
        ctl.redirect = active && !hazard && cond_true;
        ctl.flush    = DELAY_SLOT ? 1'b0 : ctl.redirect;
    end

    always_ff @(posedge clk) begin
        if (rst) shadow_q <= 1'b0;
        else     shadow_q <= ctl.redirect;
    end

    assign pc_sel   = ctl.redirect;
    assign flush_if = ctl.flush;
    assign br_stall = ctl.stall;
endmodule

// File: rtl/br_resolve_chk.sv
module br_resolve_chk #(
    parameter bit DELAY_SLOT = 1'b0
) (
    input logic       clk,
    input logic       rst,
    input logic       id_valid,
    input logic [2:0] br_kind,
    input logic       pc_sel,
    input logic       flush_if,
    input logic       br_stall
);
    p_stall_blocks_r6: assert property (@(posedge clk) disable iff (rst)
        br_stall |-> (!pc_sel && !flush_if));

    p_flush_tracks_r7: assert property (@(posedge clk) disable iff (rst)
        flush_if |-> pc_sel);

    p_slot_no_flush_r8: assert property (@(posedge clk) disable iff (rst)
        pc_sel |-> (flush_if == !DELAY_SLOT));

    p_shadow_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        pc_sel |=> (!pc_sel && !br_stall));

    p_stall_needs_br_r4: assert property (@(posedge clk) disable iff (rst)
        br_stall |-> (id_valid && br_kind != 3'd0 && br_kind != 3'd7));

    p_kind_r2: assert property (@(posedge clk) disable iff (rst)
        (br_kind == 3'd0 || br_kind == 3'd7) |-> !pc_sel);
endmodule

bind br_resolve_unit br_resolve_chk #(.DELAY_SLOT(DELAY_SLOT)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .id_valid (id_valid),
    .br_kind  (br_kind),
    .pc_sel   (pc_sel),
    .flush_if (flush_if),
    .br_stall (br_stall)
);

// File: tb/sim_br_resolve_unit.sv
module sim_br_resolve_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        id_valid = 1'b0;
    logic [2:0]  br_kind = 3'd0;
    logic [31:0] opnd_a = '0, opnd_b = '0, offset_imm = '0, pc_plus4 = '0;
    logic [4:0]  rs_idx = '0, rt_idx = '0, ex_rd = '0, mem_rd = '0;
    logic        ex_wen = 1'b0, mem_load = 1'b0;
    logic        pc_sel0, flush0, stall0, pc_sel1, flush1, stall1;
    logic [31:0] tgt0, tgt1;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit m_shadow = 1'b0;

    typedef struct {
        bit          sel;
        bit          stall;
        logic [31:0] tgt;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #10 clk = ~clk;

    br_resolve_unit #(.DELAY_SLOT(1'b0)) u0 (
        .clk(clk), .rst(rst), .id_valid(id_valid), .br_kind(br_kind),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .offset_imm(offset_imm),
        .pc_plus4(pc_plus4), .rs_idx(rs_idx), .rt_idx(rt_idx),
        .ex_wen(ex_wen), .ex_rd(ex_rd), .mem_load(mem_load), .mem_rd(mem_rd),
        .pc_sel(pc_sel0), .br_target(tgt0), .flush_if(flush0), .br_stall(stall0)
    );

    br_resolve_unit #(.DELAY_SLOT(1'b1)) u1 (
        .clk(clk), .rst(rst), .id_valid(id_valid), .br_kind(br_kind),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .offset_imm(offset_imm),
        .pc_plus4(pc_plus4), .rs_idx(rs_idx), .rt_idx(rt_idx),
        .ex_wen(ex_wen), .ex_rd(ex_rd), .mem_load(mem_load), .mem_rd(mem_rd),
        .pc_sel(pc_sel1), .br_target(tgt1), .flush_if(flush1), .br_stall(stall1)
    );

    function automatic bit model_cond(input logic [2:0] k, input logic [31:0] a, input logic [31:0] b);
        case (k)
            3'd1: return a == b;
            3'd2: return a != b;
            3'd3: return a == 0;
            3'd4: return a != 0;
            3'd5: return a[31];
            3'd6: return !a[31];
            default: return 1'b0;
        endcase
    endfunction

    task automatic drive(input bit v, input logic [2:0] k, input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] off, input logic [31:0] p4, input logic [4:0] rs,
                         input logic [4:0] rt, input bit ew, input logic [4:0] er,
                         input bit ml, input logic [4:0] mr, input string tag);
        exp_t e;
        bit   usesb, haz, act;
        @(negedge clk);
        id_valid = v; br_kind = k; opnd_a = a; opnd_b = b; offset_imm = off;
        pc_plus4 = p4; rs_idx = rs; rt_idx = rt; ex_wen = ew; ex_rd = er;
        mem_load = ml; mem_rd = mr;
        usesb = (k == 3'd1) || (k == 3'd2);
        haz = (rs != 0 && ((ew && er == rs) || (ml && mr == rs))) ||
              (usesb && rt != 0 && ((ew && er == rt) || (ml && mr == rt)));
        act = v && k != 3'd0 && k != 3'd7 && !m_shadow;
        e.stall = act && haz;
        e.sel   = act && !haz && model_cond(k, a, b);
        e.tgt   = p4 + (off << 2);
        e.tag   = tag;
        sb.push_back(e);
        m_shadow = e.sel;
    endtask

    always begin
        @(negedge clk);
        #5;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_checks++;
            if (pc_sel0 !== e.sel || flush0 !== e.sel || stall0 !== e.stall || tgt0 !== e.tgt ||
                pc_sel1 !== e.sel || flush1 !== 1'b0 || stall1 !== e.stall || tgt1 !== e.tgt) begin
                n_fail++;
                $display("FAIL %s: got sel=%0b/%0b flush=%0b/%0b stall=%0b/%0b tgt=%h exp sel=%0b flush=%0b/0 stall=%0b tgt=%h",
                         e.tag, pc_sel0, pc_sel1, flush0, flush1, stall0, stall1, tgt0,
                         e.sel, e.sel, e.stall, e.tgt);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            n_fail++;
            $display("FAIL watchdog: got %0d cycles, expected completion", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_shadow = 1'b0;
        // R1 reset: first taken branch redirects; R3 target
        drive(1, 3'd1, 32'h5, 32'h5, 32'h10, 32'h1000, 5'd1, 5'd2, 0, 0, 0, 0, "R1 first taken after reset");
        // R9: branch right behind a redirect is ignored even with hazard
        drive(1, 3'd1, 32'h7, 32'h7, 32'h4, 32'h1004, 5'd3, 5'd3, 1, 5'd3, 0, 0, "R9 shadow ignored");
        drive(0, 3'd0, 0, 0, 0, 32'h2000, 0, 0, 0, 0, 0, 0, "R2 idle");
        // R2 conditions taken and not
        drive(1, 3'd2, 32'h1, 32'h2, 32'h1, 32'h3000, 5'd1, 5'd2, 0, 0, 0, 0, "R2 NE taken");
        drive(0, 3'd0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R9 shadow idle");
        drive(1, 3'd2, 32'h9, 32'h9, 32'h1, 32'h3000, 5'd1, 5'd2, 0, 0, 0, 0, "R7 NE not taken no flush");
        drive(1, 3'd4, 32'h8000_0000, 0, 32'h20, 32'h400, 5'd4, 0, 0, 0, 0, 0, "R2 NZ top bit only");
        drive(0, 3'd0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "idle");
        drive(1, 3'd3, 32'h0000_0100, 0, 32'h20, 32'h400, 5'd4, 0, 0, 0, 0, 0, "R2 EZ not taken");
        drive(1, 3'd5, 32'hFFFF_FFFF, 0, 32'hFFFF_FFFE, 32'h400, 5'd4, 0, 0, 0, 0, 0, "R3 LTZ negative offset");
        drive(0, 3'd0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "idle");
        drive(1, 3'd6, 32'h8000_0000, 0, 32'h1, 32'h400, 5'd4, 0, 0, 0, 0, 0, "R2 GEZ negative not taken");
        drive(1, 3'd7, 32'h0, 32'h0, 32'h1, 32'h400, 5'd4, 0, 0, 0, 0, 0, "R2 reserved code");
        // R4/R6: taken condition with EX dependency on rt -> stall, then go
        drive(1, 3'd1, 32'h3, 32'h3, 32'h8, 32'h800, 5'd5, 5'd6, 1, 5'd6, 0, 0, "R4 R6 EX dep on rt stalls");
        drive(1, 3'd1, 32'h3, 32'h3, 32'h8, 32'h800, 5'd5, 5'd6, 0, 0, 0, 0, "R4 release redirects");
        drive(0, 3'd0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "idle");
        // R5: load dependency, two stall cycles
        drive(1, 3'd3, 32'h0, 0, 32'h3, 32'h900, 5'd7, 0, 1, 5'd7, 0, 0, "R5 load in EX stalls");
        drive(1, 3'd3, 32'h0, 0, 32'h3, 32'h900, 5'd7, 0, 0, 0, 1, 5'd7, "R5 load in MEM stalls");
        drive(1, 3'd3, 32'h0, 0, 32'h3, 32'h900, 5'd7, 0, 0, 0, 0, 0, "R5 load done redirect");
        drive(0, 3'd0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "idle");
        // R10: rt not used by single-operand kind; r0 never a hazard
        drive(1, 3'd4, 32'h1, 0, 32'h1, 32'hA00, 5'd8, 5'd9, 1, 5'd9, 0, 0, "R10 rt unused by NZ");
        drive(0, 3'd0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "idle");
        drive(1, 3'd1, 32'h0, 32'h0, 32'h1, 32'hB00, 5'd0, 5'd0, 1, 5'd0, 1, 5'd0, "R10 r0 never hazards");
        drive(0, 3'd0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "idle");
        // ALU in MEM (not load) causes no stall: one-cycle cost only (R5)
        drive(1, 3'd2, 32'h1, 32'h0, 32'h1, 32'hC00, 5'd10, 5'd11, 0, 0, 0, 5'd10, "R5 ALU in MEM no stall");
        // R8 / R9 under delay mode covered by flush1 in every vector
        drive(1, 3'd2, 32'h1, 32'h0, 32'h1, 32'hC04, 5'd10, 5'd11, 0, 0, 0, 0, "R8 R9 slot branch ignored");
        drive(0, 3'd0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "final idle");
        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule